// File: doc/BRIEF.md
# Clock Profile Register Bank

This block holds the frequency settings for a programmable clock synthesizer. It keeps four 48-bit profiles and a 2-bit select register in volatile registers. Each profile is six bytes wide. An asynchronous reset reloads every profile and the select value from parameters. A byte-wide register port reads and writes the storage. A serial target front end outside this block would normally drive that port.

The profile that the select register names goes to the synthesizer control logic on a single 48-bit bus. That profile is protected while it is active. A write to any of its bytes is dropped and raises a sticky error flag. To use a new setting, software rewrites one of the three idle profiles and then moves the select register to it.

When the selection changes, the block pulses a change strobe for one cycle. It then holds a relock flag for a fixed number of cycles so the downstream oscillator can settle. While that flag is high, further select writes are refused.

Top module: `clkprof_regbank`

## Requirements
- R1: While reset is asserted and after it is released, every profile byte and the select register hold their parameter defaults. The flags `chg_pulse`, `relock_busy` and `wr_err` are low.
- R2: Profile p, byte b (b = 0..5) sits at address 0x10 + 6*p + b. A read of any mapped address returns the stored byte on `reg_rdata` in the same cycle.
- R3: `prof_out` carries the selected profile, with byte 0 (the lowest address) in bits [47:40] and byte 5 in bits [7:0].
- R4: A write to a byte of a profile that is not selected stores the data at the clock edge.
- R5: A write to any byte of the selected profile leaves storage and `prof_out` unchanged and sets `wr_err`. The flag stays set until it is cleared.
- R6: Any write to address 0x40 clears `wr_err`, including one that does not change the selection.
- R7: The select register is at 0x40. Bits [1:0] pick the profile: 00 selects profile 0 and 11 selects profile 3. Bits [7:2] read as zero and ignore writes.
- R8: A write to 0x40 that changes the selection updates `sel_out` and `prof_out` at the same clock edge. `chg_pulse` is high for exactly the one cycle that follows that edge. Writing the current value produces no pulse.
- R9: After a selection change, `relock_busy` is high for exactly RELOCK_CYC cycles. Writes to 0x40 during those cycles leave the selection unchanged. The first write after the flag falls is accepted.
- R10: Reads of unmapped addresses return 0x00. Writes to unmapped addresses change no stored byte and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads the defaults |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte address for both read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| prof_out | output | 48 | Active profile, byte 0 in the top bits |
| sel_out | output | 2 | Current select value |
| chg_pulse | output | 1 | One-cycle strobe after a selection change |
| relock_busy | output | 1 | High during the relock interval |
| wr_err | output | 1 | Sticky flag for a refused write to the active profile |

## Verification
Two events can meet in one cycle: the last cycle of the relock interval and a new select write. The bench waits exactly RELOCK_CYC-1 cycles after a change and then issues a select write, so that the write meets the final busy cycle. It expects the write to be refused and the busy flag to fall at the same edge. An identical write one cycle later must be accepted and produce a fresh strobe. The same approach covers error handling during relock: a write to the active profile while busy must set the sticky error, and a refused select write that follows must still clear it.

// File: rtl/clkprof_pkg.sv
package clkprof_pkg;
   localparam int BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;

   // First address of profile p, given the base of the profile window
   function automatic int prof_base(input int base, input int nbytes, input int p);
      return base + p * nbytes;
   endfunction
endpackage

// File: rtl/clkprof_slot.sv
module clkprof_slot
   import clkprof_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int NBYTES = 6,
   parameter int LO_ADDR = 16,
   parameter logic [NBYTES*BYTE_W-1:0] DFLT = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr,
   input  logic [ADDR_W-1:0]        addr,
   input  byte_t                    wdata,
   input  logic                     locked,
   output logic [NBYTES*BYTE_W-1:0] word,
   output byte_t                    rd_byte,
   output logic                     wr_refused
);
   localparam int WORD_W = NBYTES * BYTE_W;
   localparam logic [ADDR_W-1:0] LO = ADDR_W'(LO_ADDR);
   localparam logic [ADDR_W-1:0] HI = ADDR_W'(LO_ADDR + NBYTES - 1);

   logic              hit;
   logic [ADDR_W-1:0] off;
   byte_t             mem [NBYTES];

   assign hit = (addr >= LO) && (addr <= HI);
   assign off = addr - LO;
   assign wr_refused = wr && hit && locked;

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[b] <= DFLT[WORD_W-1-b*BYTE_W -: BYTE_W];
         else if (wr && hit && !locked && off == ADDR_W'(b))
            mem[b] <= wdata;
      end
      assign word[WORD_W-1-b*BYTE_W -: BYTE_W] = mem[b];
   end

   always_comb begin
      rd_byte = '0;
      for (int b = 0; b < NBYTES; b++)
         if (hit && off == ADDR_W'(b))
            rd_byte = mem[b];
   end
endmodule

// File: rtl/clkprof_selctl.sv
module clkprof_selctl #(
   parameter int SEL_W = 2,
   parameter int RELOCK_CYC = 16,
   parameter logic [SEL_W-1:0] DFLT_SEL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_wr,
   input  logic [SEL_W-1:0] sel_new,
   output logic [SEL_W-1:0] sel,
   output logic             chg_pulse,
   output logic             busy
);
   localparam int CNT_W = $clog2(RELOCK_CYC + 1);

   logic [CNT_W-1:0] cnt;
   logic             take;

   assign busy = (cnt != '0);
   assign take = sel_wr && !busy && (sel_new != sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel       <= DFLT_SEL;
         chg_pulse <= 1'b0;
         cnt       <= '0;
      end else if (take) begin
         sel       <= sel_new;
         chg_pulse <= 1'b1;
         cnt       <= CNT_W'(RELOCK_CYC);
      end else begin
         chg_pulse <= 1'b0;
         if (busy)
            cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/clkprof_regbank.sv
module clkprof_regbank
   import clkprof_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int N_PROF = 4,
   parameter int NBYTES = 6,
   parameter int PROF_LO = 16,
   parameter int SEL_ADDR = 64,
   parameter int RELOCK_CYC = 16,
   parameter logic [N_PROF*NBYTES*8-1:0] DFLT_PROFS = '0,
   parameter logic [$clog2(N_PROF)-1:0] DFLT_SEL = '0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_wr,
   input  logic [ADDR_W-1:0]      reg_addr,
   input  logic [7:0]             reg_wdata,
   output logic [7:0]             reg_rdata,
   output logic [NBYTES*8-1:0]    prof_out,
   output logic [$clog2(N_PROF)-1:0] sel_out,
   output logic                   chg_pulse,
   output logic                   relock_busy,
   output logic                   wr_err
);
   localparam int SEL_W  = $clog2(N_PROF);
   localparam int WORD_W = NBYTES * BYTE_W;
   localparam int WIN_HI = PROF_LO + N_PROF * NBYTES - 1;

   if (N_PROF < 2 || N_PROF != (1 << SEL_W)) begin : g_chk_nprof
      $error("N_PROF must be a power of two and at least 2");
   end
   if (RELOCK_CYC < 1) begin : g_chk_relock
      $error("RELOCK_CYC must be at least 1");
   end
   if (SEL_ADDR >= PROF_LO && SEL_ADDR <= WIN_HI) begin : g_chk_map
      $error("select address overlaps the profile window");
   end
   if (WIN_HI >= (1 << ADDR_W) || SEL_ADDR >= (1 << ADDR_W)) begin : g_chk_aw
      $error("address map exceeds ADDR_W");
   end

   logic              sel_hit;
   logic [WORD_W-1:0] words   [N_PROF];
   byte_t             rbytes  [N_PROF];
   logic [N_PROF-1:0] refused;
   logic              err_q;

   assign sel_hit = (reg_addr == ADDR_W'(SEL_ADDR));

   clkprof_selctl #(
      .SEL_W(SEL_W), .RELOCK_CYC(RELOCK_CYC), .DFLT_SEL(DFLT_SEL)
   ) u_sel (
      .clk(clk), .rst_n(rst_n),
      .sel_wr(reg_wr && sel_hit), .sel_new(reg_wdata[SEL_W-1:0]),
      .sel(sel_out), .chg_pulse(chg_pulse), .busy(relock_busy)
   );

   for (genvar p = 0; p < N_PROF; p++) begin : g_prof
      clkprof_slot #(
         .ADDR_W(ADDR_W), .NBYTES(NBYTES),
         .LO_ADDR(prof_base(PROF_LO, NBYTES, p)),
         .DFLT(DFLT_PROFS[p*WORD_W +: WORD_W])
      ) u_slot (
         .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
         .wdata(reg_wdata), .locked(sel_out == SEL_W'(p)),
         .word(words[p]), .rd_byte(rbytes[p]), .wr_refused(refused[p])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         err_q <= 1'b0;
      else if (reg_wr && sel_hit)
         err_q <= 1'b0;
      else if (|refused)
         err_q <= 1'b1;
   end
   assign wr_err = err_q;

   always_comb begin
      prof_out = '0;
      for (int p = 0; p < N_PROF; p++)
         if (sel_out == SEL_W'(p))
            prof_out = words[p];
   end

   always_comb begin
      reg_rdata = '0;
      for (int p = 0; p < N_PROF; p++)
         reg_rdata = reg_rdata | rbytes[p];
      if (sel_hit)
         reg_rdata = {{(8-SEL_W){1'b0}}, sel_out};
   end
endmodule

// File: rtl/clkprof_regbank_chk.sv
module clkprof_regbank_chk #(
   parameter int ADDR_W = 8,
   parameter int N_PROF = 4,
   parameter int NBYTES = 6,
   parameter int PROF_LO = 16,
   parameter int SEL_ADDR = 64
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      reg_wr,
   input logic [ADDR_W-1:0]         reg_addr,
   input logic [7:0]                reg_rdata,
   input logic [NBYTES*8-1:0]       prof_out,
   input logic [$clog2(N_PROF)-1:0] sel_out,
   input logic                      chg_pulse,
   input logic                      relock_busy,
   input logic                      wr_err
);
   logic [ADDR_W:0] act_lo, act_hi;
   logic            act_wr, sel_wr;

   assign act_lo = (ADDR_W+1)'(PROF_LO) + (ADDR_W+1)'(sel_out) * (ADDR_W+1)'(NBYTES);
   assign act_hi = act_lo + (ADDR_W+1)'(NBYTES - 1);
   assign act_wr = reg_wr && ({1'b0, reg_addr} >= act_lo) && ({1'b0, reg_addr} <= act_hi);
   assign sel_wr = reg_wr && (reg_addr == ADDR_W'(SEL_ADDR));

   AST_ACTIVE_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      act_wr |=> (wr_err && $stable(prof_out)));                    // R5
   AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr |=> !wr_err);                                          // R6
   AST_SEL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(SEL_ADDR)) |-> (reg_rdata[7:2] == 6'd0)); // R7
   AST_CHANGE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sel_out) |-> chg_pulse);                             // R8
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      chg_pulse |=> !chg_pulse);                                    // R8
   AST_STROBE_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      chg_pulse |-> relock_busy);                                   // R9
   AST_SEL_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(relock_busy) |-> $stable(sel_out));                     // R9
endmodule

bind clkprof_regbank clkprof_regbank_chk #(
   .ADDR_W(ADDR_W), .N_PROF(N_PROF), .NBYTES(NBYTES),
   .PROF_LO(PROF_LO), .SEL_ADDR(SEL_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_rdata(reg_rdata), .prof_out(prof_out), .sel_out(sel_out),
   .chg_pulse(chg_pulse), .relock_busy(relock_busy), .wr_err(wr_err)
);

// File: tb/clkprof_regbank_tb_top.sv
module clkprof_regbank_tb_top;
   localparam int CLK_P = 10;
   localparam int RLK = 5;
   localparam logic [47:0] P0 = 48'hA0A1A2A3A4A5;
   localparam logic [47:0] P1 = 48'hB0B1B2B3B4B5;
   localparam logic [47:0] P2 = 48'hC0C1C2C3C4C5;
   localparam logic [47:0] P3 = 48'hD0D1D2D3D4D5;

   // entry: {write, addr, wdata, expected read, requirement number}
   localparam int NV = 11;
   localparam logic [32:0] VEC [NV] = '{
      {1'b0, 8'h10, 8'h00, 8'hA0, 8'd2},   // R2 profile 0 byte 0
      {1'b0, 8'h15, 8'h00, 8'hA5, 8'd2},   // R2 profile 0 byte 5
      {1'b0, 8'h16, 8'h00, 8'hB0, 8'd2},   // R2 profile 1 byte 0
      {1'b0, 8'h27, 8'h00, 8'hD5, 8'd2},   // R2 profile 3 byte 5
      {1'b0, 8'h40, 8'h00, 8'h01, 8'd1},   // R1 default select
      {1'b0, 8'h0F, 8'h00, 8'h00, 8'd10},  // R10 below window
      {1'b0, 8'h28, 8'h00, 8'h00, 8'd10},  // R10 above window
      {1'b1, 8'h1C, 8'h5A, 8'h00, 8'd4},   // R4 write idle profile 2
      {1'b0, 8'h1C, 8'h00, 8'h5A, 8'd4},
      {1'b1, 8'h30, 8'hFF, 8'h00, 8'd10},  // R10 unmapped write
      {1'b0, 8'h30, 8'h00, 8'h00, 8'd10}
   };

   logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
   logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
   logic [47:0] prof_out;
   logic [1:0] sel_out;
   logic chg_pulse, relock_busy, wr_err;
   int checks = 0, errors = 0;

   always #(CLK_P/2) clk = ~clk;

   clkprof_regbank #(
      .RELOCK_CYC(RLK), .DFLT_PROFS({P3, P2, P1, P0}), .DFLT_SEL(2'd1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prof_out(prof_out),
      .sel_out(sel_out), .chg_pulse(chg_pulse), .relock_busy(relock_busy),
      .wr_err(wr_err)
   );

   task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
      reg_addr = a;
      #1;
      chk(reg_rdata == exp, req, reg_rdata, exp);
   endtask

   initial begin
      #(CLK_P * 50000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      chk(prof_out == P1 && !chg_pulse && !relock_busy && !wr_err, "R1 in reset", prof_out, P1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(prof_out == P1 && !chg_pulse && !relock_busy && !wr_err, "R1 after reset", prof_out, P1);
      chk(prof_out[47:40] == 8'hB0, "R3 byte0 in top bits", prof_out[47:40], 8'hB0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][32]) do_wr(VEC[i][31:24], VEC[i][23:16]);
         else rd_chk(VEC[i][31:24], VEC[i][15:8], $sformatf("R%0d vector %0d", VEC[i][7:0], i));
         @(negedge clk);
      end

      // R5: protected write
      do_wr(8'h18, 8'h00);
      chk(wr_err && prof_out == P1, "R5 active write refused", {wr_err, prof_out}, {1'b1, P1});
      rd_chk(8'h18, 8'hB2, "R5 stored byte kept");
      @(negedge clk);
      chk(wr_err, "R5 sticky", wr_err, 1);

      // R6, R8: same value clears error, no strobe
      do_wr(8'h40, 8'h01);
      chk(!wr_err, "R6 clear", wr_err, 0);
      chk(!chg_pulse && !relock_busy, "R8 no strobe same value", {chg_pulse, relock_busy}, 0);

      // R7, R8, R3: change to profile 2 with upper bits set
      do_wr(8'h40, 8'hFE);
      chk(chg_pulse && relock_busy, "R8 strobe", {chg_pulse, relock_busy}, 3);
      chk(prof_out == 48'h5AC1C2C3C4C5, "R3 new profile", prof_out, 48'h5AC1C2C3C4C5);
      rd_chk(8'h40, 8'h02, "R7 select readback");
      n = 0;
      for (int k = 0; k < 100 && relock_busy; k++) begin
         n++;
         if (n == 2) chk(!chg_pulse, "R8 strobe one cycle", chg_pulse, 0);
         @(negedge clk);
      end
      chk(n == RLK, "R9 busy length", n, RLK);

      // R9, R5, R6 during relock
      do_wr(8'h40, 8'h03);
      do_wr(8'h22, 8'h11);
      chk(wr_err && relock_busy, "R5 refused while busy", {wr_err, relock_busy}, 3);
      do_wr(8'h40, 8'h00);
      chk(!wr_err, "R6 clear while busy", wr_err, 0);
      rd_chk(8'h40, 8'h03, "R9 select ignored while busy");
      for (int k = 0; k < 100 && relock_busy; k++) @(negedge clk);
      rd_chk(8'h40, 8'h03, "R9 select after busy");
      rd_chk(8'h22, 8'hD0, "R5 profile 3 intact");

      // R9 boundary: write lands on the last busy cycle
      do_wr(8'h40, 8'h01);
      repeat (RLK - 1) @(negedge clk);
      chk(relock_busy, "R9 last busy cycle", relock_busy, 1);
      do_wr(8'h40, 8'h02);
      chk(!relock_busy && !chg_pulse, "R9 refused at last cycle", {relock_busy, chg_pulse}, 0);
      rd_chk(8'h40, 8'h01, "R9 select unchanged at boundary");
      do_wr(8'h40, 8'h02);
      chk(chg_pulse && sel_out == 2'd2, "R9 accepted after busy", {chg_pulse, sel_out}, 3'b110);

      // R1: reset restores defaults
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd_chk(8'h1C, 8'hC0, "R1 profile 2 restored");
      rd_chk(8'h40, 8'h01, "R1 select restored");
      chk(!relock_busy && !chg_pulse && prof_out == P1, "R1 flags restored", prof_out, P1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule